// File: doc/BRIEF.md
# UART bit-rate and break timer

This block derives the timing for a serial port from the system clock. A two-stage divider, a predivider followed by a main divisor, both loaded from one write as stored minus-one fields, produces an oversample tick. Thirteen oversample ticks make one bit time, and the block marks the last tick of each bit with a bit tick. The bit rate is therefore clock / predivider / 13 / divisor, where both values are the programmed field plus one. The supported range covers slow and fast ports alike, from roughly 900 to 921600 bit/s from a suitable clock.

A new divisor does not take effect at once. It waits in a holding register until the line is idle or the current bit time ends, so that no bit comes out with a mixed length. A busy flag shows that a change is still pending. The same block also times a break: a start strobe forces the transmit line low for a programmed number of units, where one unit is 16 oversample ticks. The break request then clears itself, and a one-cycle completion pulse follows. Because the unit is built from the oversample tick, the break length scales with the bit rate, and software sets the count to about rate x 4096 / 1e6.

Top module: `uart_baud_brk`

## Requirements
- R1: After reset, div_busy_o, brk_active_o and brk_done_o are 0, txd_o equals tx_ser_i, and the divisor fields are zero.
- R2: A divisor write takes the predivider minus one from div_wdata_i[19:16] and the divisor minus one from div_wdata_i[9:0]. Once it is loaded, os_tick_o pulses for one cycle every P*D clocks, where P and D are the fields plus one.
- R3: bit_tick_o pulses on every 13th os_tick_o and only together with one, so that bit ticks are 13*P*D clocks apart.
- R4: div_busy_o is 1 in the cycle after a divisor write. While line_idle_i is 1, the load happens at the next edge and div_busy_o returns to 0 in the cycle after that.
- R5: While line_idle_i is 0, a pending divisor loads only at the edge that ends a cycle with bit_tick_o high. div_busy_o falls after that edge, and the counters restart with the new rate.
- R6: A brk_start_i pulse while no break is active sets brk_active_o from the next cycle. txd_o is 0 in every cycle with brk_active_o high.
- R7: With a break length L > 0 (written through brk_len_wr_i), brk_active_o stays high for exactly 16*L os_tick_o pulses and clears at the edge ending the last of them.
- R8: brk_done_o is high for exactly one cycle, the first cycle with brk_active_o low after a break.
- R9: A brk_start_i pulse during an active break is ignored: the break keeps its length and produces a single brk_done_o.
- R10: With L = 0, brk_active_o is high for a single cycle and brk_done_o follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wr_i | input | 1 | Divisor write strobe |
| div_wdata_i | input | 32 | Divisor word: [19:16] predivider-1, [9:0] divisor-1 |
| line_idle_i | input | 1 | Transmitter idle; allows an immediate divisor load |
| brk_len_wr_i | input | 1 | Break length write strobe |
| brk_len_i | input | BRK_W | Break length in units of 16 oversample ticks |
| brk_start_i | input | 1 | Break request strobe |
| tx_ser_i | input | 1 | Serial data from the transmit shifter |
| os_tick_o | output | 1 | Oversample tick |
| bit_tick_o | output | 1 | Bit-time boundary tick |
| div_busy_o | output | 1 | New divisor pending |
| brk_active_o | output | 1 | Break request bit, self-clearing |
| brk_done_o | output | 1 | Break completion pulse |
| txd_o | output | 1 | Transmit line |

## Verification
The bench sweeps every predivider and divisor pair from 1 to 4 and measures the oversample spacing, the bit spacing and the ticks per bit. An off-by-one in either stored field would stretch or shrink these spacings by a whole factor. It writes a divisor just after a bit boundary on a busy line and expects the busy flag to last exactly one old bit time. A design that loaded at once, or that lost a write landing on the boundary edge, would release the flag early or late. Break runs at several lengths and rates count oversample ticks while the line is low and check for a single completion pulse. A stray retrigger in mid-break, or a zero length that counts the full range, would show up as a longer break or a second pulse.

// File: rtl/uart_bg_pkg.sv
package uart_bg_pkg;
  localparam int PRE_W   = 4;
  localparam int DIV_W   = 10;
  localparam int PRE_LSB = 16;
  localparam int DIV_LSB = 0;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic [PRE_W-1:0] pre_m1;
    logic [DIV_W-1:0] div_m1;
  } rate_cfg_t;
endpackage

// File: rtl/uart_bg_divreg.sv
module uart_bg_divreg
  import uart_bg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  rate_cfg_t wcfg_i,
  input  logic      load_i,
  output logic      busy_o,
  output rate_cfg_t pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      pend_o <= '0;
    end else if (wr_i) begin
      busy_o <= 1'b1;
      pend_o <= wcfg_i;
    end else if (load_i) begin
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_bg_divcnt.sv
module uart_bg_divcnt
  import uart_bg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  rate_cfg_t cfg_i,
  output logic      os_tick_o
);
  rate_cfg_t        cfg_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_hit;
  logic             div_hit;

  assign pre_hit   = (pre_cnt == cfg_q.pre_m1);
  assign div_hit   = (div_cnt == cfg_q.div_m1);
  assign os_tick_o = pre_hit && div_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (load_i) begin
      cfg_q   <= cfg_i;
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
      if (pre_hit) div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_bg_phase.sv
module uart_bg_phase #(
  parameter int OS_PER_BIT = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic os_tick_i,
  output logic bit_tick_o
);
  localparam int PH_W = (OS_PER_BIT > 1) ? $clog2(OS_PER_BIT) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS_PER_BIT - 1);

  logic [PH_W-1:0] ph_q;

  assign bit_tick_o = os_tick_i && (ph_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (clr_i)     ph_q <= '0;
    else if (os_tick_i) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/uart_bg_break.sv
module uart_bg_break #(
  parameter int LEN_W      = 16,
  parameter int UNIT_TICKS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             len_wr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             start_i,
  input  logic             os_tick_i,
  output logic             active_o,
  output logic             done_o
);
  localparam int SUB_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_TICKS - 1);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] unit_q;
  logic [SUB_W-1:0] sub_q;
  logic             unit_end;
  logic             finish;

  assign unit_end = os_tick_i && (sub_q == SUB_LAST);
  // zero length ends on the first edge; otherwise at the last tick of the last unit
  assign finish   = active_o && ((len_q == '0) ||
                    (unit_end && (unit_q == len_q - 1'b1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      unit_q   <= '0;
      sub_q    <= '0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish;
      if (len_wr_i) len_q <= len_i;
      if (!active_o && start_i) begin
        active_o <= 1'b1;
        unit_q   <= '0;
        sub_q    <= '0;
      end else if (finish) begin
        active_o <= 1'b0;
      end else if (active_o && os_tick_i) begin
        sub_q <= unit_end ? '0 : sub_q + 1'b1;
        if (unit_end) unit_q <= unit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_baud_brk.sv
module uart_baud_brk
  import uart_bg_pkg::*;
#(
  parameter int OS_PER_BIT     = 13,
  parameter int BRK_W          = 16,
  parameter int BRK_UNIT_TICKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_wr_i,
  input  logic [WORD_W-1:0] div_wdata_i,
  input  logic              line_idle_i,
  input  logic              brk_len_wr_i,
  input  logic [BRK_W-1:0]  brk_len_i,
  input  logic              brk_start_i,
  input  logic              tx_ser_i,
  output logic              os_tick_o,
  output logic              bit_tick_o,
  output logic              div_busy_o,
  output logic              brk_active_o,
  output logic              brk_done_o,
  output logic              txd_o
);
  localparam logic [WORD_W-1:0] USED_MASK =
    ((WORD_W'(1) << PRE_W) - 1'b1) << PRE_LSB |
    ((WORD_W'(1) << DIV_W) - 1'b1) << DIV_LSB;

  rate_cfg_t wcfg;
  rate_cfg_t pend_cfg;
  logic      load;
  logic      unused_bits;

  assign wcfg.pre_m1 = div_wdata_i[PRE_LSB +: PRE_W];
  assign wcfg.div_m1 = div_wdata_i[DIV_LSB +: DIV_W];
  assign unused_bits = ^(div_wdata_i & ~USED_MASK);

  // a write in the same cycle wins; the load waits for the next boundary
  assign load = div_busy_o && !div_wr_i && (line_idle_i || bit_tick_o);

  uart_bg_divreg u_divreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (div_wr_i),
    .wcfg_i (wcfg),
    .load_i (load),
    .busy_o (div_busy_o),
    .pend_o (pend_cfg)
  );

  uart_bg_divcnt u_divcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .cfg_i     (pend_cfg),
    .os_tick_o (os_tick_o)
  );

  uart_bg_phase #(.OS_PER_BIT(OS_PER_BIT)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (load),
    .os_tick_i  (os_tick_o),
    .bit_tick_o (bit_tick_o)
  );

  uart_bg_break #(.LEN_W(BRK_W), .UNIT_TICKS(BRK_UNIT_TICKS)) u_break (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .len_wr_i  (brk_len_wr_i),
    .len_i     (brk_len_i),
    .start_i   (brk_start_i),
    .os_tick_i (os_tick_o),
    .active_o  (brk_active_o),
    .done_o    (brk_done_o)
  );

  assign txd_o = brk_active_o ? 1'b0 : tx_ser_i;
endmodule

// File: rtl/uart_baud_brk_chk.sv
module uart_baud_brk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic div_wr_i,
  input logic line_idle_i,
  input logic brk_start_i,
  input logic os_tick_o,
  input logic bit_tick_o,
  input logic div_busy_o,
  input logic brk_active_o,
  input logic brk_done_o,
  input logic txd_o
);
  // R4
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr_i |=> div_busy_o);

  // R5
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_busy_o) |-> $past(line_idle_i || bit_tick_o));

  // R3
  bit_on_os_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);

  // R6
  brk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_active_o |-> !txd_o);

  // R6
  brk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_active_o) |-> $past(brk_start_i));

  // R8
  brk_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_done_o |-> (!brk_active_o && $past(brk_active_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_done_o |=> !brk_done_o);
endmodule

bind uart_baud_brk uart_baud_brk_chk chk_i (.*);

// File: tb/uart_baud_brk_tb_top.sv
module uart_baud_brk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BRK_W      = 16;
  localparam int WDOG       = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             div_wr = 1'b0;
  logic [31:0]      div_wdata = '0;
  logic             line_idle = 1'b1;
  logic             brk_len_wr = 1'b0;
  logic [BRK_W-1:0] brk_len = '0;
  logic             brk_start = 1'b0;
  logic             tx_ser = 1'b1;
  logic os_tick, bit_tick, div_busy, brk_active, brk_done, txd;

  int n_chk = 0;
  int n_err = 0;
  int cur_p = 1;
  int cur_d = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_baud_brk #(.BRK_W(BRK_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_wr_i(div_wr), .div_wdata_i(div_wdata),
    .line_idle_i(line_idle), .brk_len_wr_i(brk_len_wr), .brk_len_i(brk_len),
    .brk_start_i(brk_start), .tx_ser_i(tx_ser), .os_tick_o(os_tick),
    .bit_tick_o(bit_tick), .div_busy_o(div_busy), .brk_active_o(brk_active),
    .brk_done_o(brk_done), .txd_o(txd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic logic [31:0] word(input int p, input int d);
    return (32'(p - 1) << 16) | 32'(d - 1);
  endfunction

  // idle-line write: busy for one sample, then loaded
  task automatic set_rate_idle(input int p, input int d);
    line_idle = 1'b1;
    div_wr = 1'b1;
    div_wdata = word(p, d);
    @(negedge clk);
    div_wr = 1'b0;
    chk("R4 busy after write", int'(div_busy), 1);
    @(negedge clk);
    chk("R4 busy cleared on idle line", int'(div_busy), 0);
    cur_p = p;
    cur_d = d;
  endtask

  task automatic measure(input string tag);
    int n;
    int os_n;
    while (!os_tick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!os_tick);
    chk({"R2 os tick spacing ", tag}, n, cur_p * cur_d);
    while (!bit_tick) @(negedge clk);
    n = 0;
    os_n = 0;
    do begin
      @(negedge clk);
      n++;
      if (os_tick) os_n++;
    end while (!bit_tick);
    chk({"R3 bit tick spacing ", tag}, n, 13 * cur_p * cur_d);
    chk({"R3 os ticks per bit ", tag}, os_n, 13);
  endtask

  task automatic run_brk(input int len, input bit retrig);
    int ticks;
    int cyc;
    int low_bad;
    brk_len_wr = 1'b1;
    brk_len = BRK_W'(len);
    @(negedge clk);
    brk_len_wr = 1'b0;
    brk_start = 1'b1;
    @(negedge clk);
    brk_start = 1'b0;
    chk("R6 break active after start", int'(brk_active), 1);
    ticks = 0;
    cyc = 0;
    low_bad = 0;
    while (brk_active) begin
      if (os_tick) ticks++;
      if (txd !== 1'b0) low_bad++;
      brk_start = retrig && (cyc == 3);
      cyc++;
      @(negedge clk);
    end
    brk_start = 1'b0;
    chk("R6 line low during break", low_bad, 0);
    if (len == 0) chk("R10 zero length lasts one cycle", cyc, 1);
    else if (retrig) chk("R9 retrigger ignored, length kept", ticks, 16 * len);
    else chk("R7 break tick count", ticks, 16 * len);
    chk("R8 done after break", int'(brk_done), 1);
    chk("R6 line released", int'(txd), 1);
    @(negedge clk);
    chk("R8 done is one cycle", int'(brk_done), 0);
    if (retrig) begin
      repeat (4) @(negedge clk);
      chk("R9 no second break", int'(brk_active), 0);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=done", WDOG);
    summary();
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy at reset", int'(div_busy), 0);
    chk("R1 break at reset", int'(brk_active), 0);
    chk("R1 done at reset", int'(brk_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd follows data high", int'(txd), 1);
    tx_ser = 1'b0;
    @(negedge clk);
    chk("R1 txd follows data low", int'(txd), 0);
    tx_ser = 1'b1;
    measure("reset fields");

    for (int p = 1; p <= 4; p++)
      for (int d = 1; d <= 4; d++) begin
        set_rate_idle(p, d);
        measure($sformatf("p%0d d%0d", p, d));
      end

    // R5: change on a busy line right at a bit boundary
    set_rate_idle(2, 3);
    line_idle = 1'b0;
    while (!bit_tick) @(negedge clk);
    div_wr = 1'b1;
    div_wdata = word(3, 2);
    @(negedge clk);
    div_wr = 1'b0;
    seen = 0;
    begin
      bit prev_bt;
      prev_bt = 1'b0;
      while (div_busy) begin
        seen++;
        prev_bt = bit_tick;
        @(negedge clk);
      end
      chk("R5 load follows a bit tick", int'(prev_bt), 1);
    end
    chk("R5 busy lasts one old bit time", seen, 13 * 2 * 3);
    cur_p = 3;
    cur_d = 2;
    measure("after busy-line change");

    // a second, larger busy-line change
    while (!bit_tick) @(negedge clk);
    repeat (5) @(negedge clk);
    div_wr = 1'b1;
    div_wdata = word(1, 4);
    @(negedge clk);
    div_wr = 1'b0;
    seen = 0;
    while (div_busy) begin seen++; @(negedge clk); end
    chk("R5 busy until boundary", seen, 13 * 3 * 2 - 5);
    cur_p = 1;
    cur_d = 4;
    measure("after mid-bit change");
    line_idle = 1'b1;

    set_rate_idle(1, 1);
    for (int l = 0; l <= 3; l++) run_brk(l, 1'b0);
    set_rate_idle(2, 2);
    for (int l = 1; l <= 3; l++) run_brk(l, 1'b0);
    run_brk(2, 1'b1);
    set_rate_idle(3, 1);
    run_brk(0, 1'b0);

    summary();
    $finish;
  end
endmodule